// File: doc/BRIEF.md
# Best-Three Distinct Track Selector

Each clock cycle the block receives nine assembled track candidates. Every candidate has a 6-bit rank, where a larger value is a better track, and a 9-bit identifier. The identifier packs one field per detector station, and each field names the segment that station contributed. The block finds every pair of candidates that use the same segment in any station and removes the weaker candidate of each pair. It then orders the remaining candidates by rank and presents at most three of them. Each output slot carries a valid flag, the rank, the identifier and the index of the input the track came from.

A single mode input selects how the identifier is split into station fields. There are two layouts: one for the pure endcap geometry and one for the barrel/endcap overlap geometry. The block is fully pipelined. It takes a new set of nine candidates every cycle and returns the result for each set exactly two cycles later.

Top module: `trk_best3_sel`

## Requirements
- R1: While `rst` is high at a rising edge, all three `out_valid` bits are 0 after that edge, whatever the candidate inputs are.
- R2: The result for a candidate set presented before rising edge k appears on the outputs after edge k+1. A new set is accepted at every edge, with no gaps.
- R3: A candidate whose rank is 0 is never selected and never removes another candidate.
- R4: When `geom_overlap` is 0, the identifier fields are id[8:6] for station 1, id[5:4] for station 2, id[3:2] for station 3 and id[1:0] for station 4.
- R5: When `geom_overlap` is 1, the identifier fields are id[8:7] for barrel station 1, id[6:5] for barrel station 2, id[4:2] for endcap station 1 and id[1:0] for endcap station 2.
- R6: Two candidates conflict when at least one station field is nonzero and equal in both. A field value of 0 means the station has no segment and never causes a conflict.
- R7: For each conflicting pair of nonzero-rank candidates, the candidate with the lower rank is removed. When the ranks are equal, the candidate with the higher input index is removed.
- R8: Removal is decided pairwise against every nonzero-rank candidate that outranks a given candidate, even if that stronger candidate is itself removed by a third candidate.
- R9: Surviving candidates fill the slots in descending rank order. Slot 0 holds the best survivor. Equal ranks are ordered by lower input index first.
- R10: If fewer than three candidates survive, the unused upper slots have valid 0 and rank, identifier and index all 0. A valid slot is never preceded by an invalid one.
- R11: A valid slot carries the rank and identifier of its source candidate exactly, and that candidate's input index (0 to 8).
- R12: No two valid output slots share a nonzero station field under the active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| geom_overlap | input | 1 | 0: endcap field layout, 1: overlap field layout |
| cand_rank | input | 54 | Nine ranks; candidate i at bits [6i+5:6i] |
| cand_id | input | 81 | Nine identifiers; candidate i at bits [9i+8:9i] |
| out_valid | output | 3 | Valid flag per output slot; slot k at bit k |
| out_rank | output | 18 | Slot k rank at bits [6k+5:6k] |
| out_id | output | 27 | Slot k identifier at bits [9k+8:9k] |
| out_idx | output | 12 | Slot k source index at bits [4k+3:4k] |

## Verification
The internal state consists of the registered survivor mask with its candidates, and the registered slot contents. A wrong survivor bit shows up two cycles after the faulty set as one of two errors: a missing track, or an extra track that shares a segment with a better one. A fault in position counting shows up after one more cycle as slots that are out of rank order, duplicated or left empty. Because every set is checked against an arithmetic model at its exact output cycle, any error is tied to a single crossing. Directed sets separate the two field layouts and cover the zero-field, tie and chained-conflict rules. A long sweep with narrow rank ranges then forces frequent ties and collisions.

// File: rtl/trk_sel_pkg.sv
package trk_sel_pkg;

    localparam int N_CAND  = 9;
    localparam int N_OUT   = 3;
    localparam int RANK_W  = 6;
    localparam int ID_W    = 9;   // field layouts below assume 9 bits
    localparam int N_FIELD = 4;
    localparam int FIELD_W = 3;   // widest station field
    localparam int IDX_W   = $clog2(N_CAND);
    localparam int POS_W   = $clog2(N_CAND + 1);

    typedef logic [RANK_W-1:0] rank_t;
    typedef logic [ID_W-1:0]   segid_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [POS_W-1:0]  pos_t;

    typedef enum logic {
        GEOM_ENDCAP  = 1'b0,
        GEOM_OVERLAP = 1'b1
    } geom_e;

    typedef struct packed {
        rank_t  rank;
        segid_t id;
    } cand_t;

    typedef struct packed {
        logic   valid;
        rank_t  rank;
        segid_t id;
        idx_t   idx;
    } trk_t;

    // Split an identifier into its per-station fields for the given layout.
    function automatic logic [N_FIELD*FIELD_W-1:0] split_fields(segid_t a, geom_e g);
        logic [N_FIELD*FIELD_W-1:0] f;
        if (g == GEOM_ENDCAP) begin
            f = {a[8:6], 1'b0, a[5:4], 1'b0, a[3:2], 1'b0, a[1:0]};
        end else begin
            f = {1'b0, a[8:7], 1'b0, a[6:5], a[4:2], 1'b0, a[1:0]};
        end
        return f;
    endfunction

    // One bit per station: both fields nonzero and equal.
    function automatic logic [N_FIELD-1:0] field_match(segid_t a, segid_t b, geom_e g);
        logic [N_FIELD*FIELD_W-1:0] fa;
        logic [N_FIELD*FIELD_W-1:0] fb;
        logic [N_FIELD-1:0]         m;
        fa = split_fields(a, g);
        fb = split_fields(b, g);
        for (int f = 0; f < N_FIELD; f++) begin
            m[f] = (fa[f*FIELD_W +: FIELD_W] != '0) &&
                   (fa[f*FIELD_W +: FIELD_W] == fb[f*FIELD_W +: FIELD_W]);
        end
        return m;
    endfunction

    function automatic logic shares_segment(segid_t a, segid_t b, geom_e g);
        return |field_match(a, b, g);
    endfunction

    // True when candidate (ra, ia) is ahead of candidate (rb, ib).
    function automatic logic outranks(rank_t ra, int ia, rank_t rb, int ib);
        return (ra > rb) || ((ra == rb) && (ia < ib));
    endfunction

endpackage

// File: rtl/trk_dup_cancel.sv
module trk_dup_cancel
    import trk_sel_pkg::*;
#(
    parameter int N = N_CAND
) (
    input  logic   clk,
    input  logic   rst,
    input  geom_e  geom_i,
    input  cand_t  cand_i [N],
    output cand_t  cand_q [N],
    output logic [N-1:0] keep_q,
    output geom_e  geom_q
);

    logic [N-1:0] keep_d;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            keep_d[i] = (cand_i[i].rank != '0);
            for (int j = 0; j < N; j++) begin
                if (j != i && cand_i[j].rank != '0 &&
                    outranks(cand_i[j].rank, j, cand_i[i].rank, i) &&
                    shares_segment(cand_i[j].id, cand_i[i].id, geom_i)) begin
                    keep_d[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            keep_q <= '0;
            geom_q <= GEOM_ENDCAP;
        end else begin
            keep_q <= keep_d;
            geom_q <= geom_i;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) cand_q[i] <= '0;
            else     cand_q[i] <= cand_i[i];
        end

        // R3: a registered survivor always has a nonzero rank
        p_survivor_ranked_r3: assert property (@(posedge clk) disable iff (rst)
            keep_q[i] |-> (cand_q[i].rank != '0));

        for (genvar j = i + 1; j < N; j++) begin : g_pair
            // R12: survivors never share a station segment
            p_survivors_disjoint_r12: assert property (@(posedge clk) disable iff (rst)
                (keep_q[i] && keep_q[j]) |-> !shares_segment(cand_q[i].id, cand_q[j].id, geom_q));
        end
    end

endmodule

// File: rtl/trk_rank_select.sv
module trk_rank_select
    import trk_sel_pkg::*;
#(
    parameter int N = N_CAND,
    parameter int M = N_OUT
) (
    input  logic   clk,
    input  logic   rst,
    input  cand_t  cand_i [N],
    input  logic [N-1:0] keep_i,
    output trk_t   trk_q [M]
);

    // Position of each survivor = number of survivors ahead of it.
    pos_t pos [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            pos[i] = '0;
            for (int j = 0; j < N; j++) begin
                if (j != i && keep_i[j] &&
                    outranks(cand_i[j].rank, j, cand_i[i].rank, i)) begin
                    pos[i] = pos[i] + pos_t'(1);
                end
            end
        end
    end

    for (genvar k = 0; k < M; k++) begin : g_slot
        logic [N-1:0] hit;
        trk_t         pick;

        always_comb begin
            pick = '0;
            for (int i = 0; i < N; i++) begin
                hit[i] = keep_i[i] && (pos[i] == pos_t'(k));
                if (hit[i]) begin
                    pick.valid = 1'b1;
                    pick.rank  = cand_i[i].rank;
                    pick.id    = cand_i[i].id;
                    pick.idx   = idx_t'(i);
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) trk_q[k] <= '0;
            else     trk_q[k] <= pick;
        end

        // R9: at most one survivor claims each slot
        p_slot_unique_r9: assert property (@(posedge clk) disable iff (rst)
            $onehot0(hit));

        // R3: a valid slot never holds a zero rank
        p_valid_ranked_r3: assert property (@(posedge clk) disable iff (rst)
            trk_q[k].valid |-> (trk_q[k].rank != '0));

        // R10: an empty slot is all zero
        p_empty_clean_r10: assert property (@(posedge clk) disable iff (rst)
            !trk_q[k].valid |-> (trk_q[k] == '0));

        if (k > 0) begin : g_order
            // R10: slots fill from the bottom
            p_slots_packed_r10: assert property (@(posedge clk) disable iff (rst)
                trk_q[k].valid |-> trk_q[k-1].valid);
            // R9: descending rank, lower index first on ties
            p_rank_order_r9: assert property (@(posedge clk) disable iff (rst)
                trk_q[k].valid |-> outranks(trk_q[k-1].rank, int'(trk_q[k-1].idx),
                                            trk_q[k].rank, int'(trk_q[k].idx)));
        end
    end

endmodule

// File: rtl/trk_best3_sel.sv
module trk_best3_sel
    import trk_sel_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     geom_overlap,
    input  logic [N_CAND*RANK_W-1:0] cand_rank,
    input  logic [N_CAND*ID_W-1:0]   cand_id,
    output logic [N_OUT-1:0]         out_valid,
    output logic [N_OUT*RANK_W-1:0]  out_rank,
    output logic [N_OUT*ID_W-1:0]    out_id,
    output logic [N_OUT*IDX_W-1:0]   out_idx
);

    cand_t        cand_in [N_CAND];
    cand_t        cand_s1 [N_CAND];
    logic [N_CAND-1:0] keep_s1;
    geom_e        geom_s1;
    geom_e        geom_in;
    trk_t         trk_s2  [N_OUT];

    assign geom_in = geom_overlap ? GEOM_OVERLAP : GEOM_ENDCAP;

    for (genvar i = 0; i < N_CAND; i++) begin : g_unpack
        assign cand_in[i].rank = cand_rank[i*RANK_W +: RANK_W];
        assign cand_in[i].id   = cand_id[i*ID_W +: ID_W];
    end

    trk_dup_cancel #(.N(N_CAND)) u_cancel (
        .clk    (clk),
        .rst    (rst),
        .geom_i (geom_in),
        .cand_i (cand_in),
        .cand_q (cand_s1),
        .keep_q (keep_s1),
        .geom_q (geom_s1)
    );

    trk_rank_select #(.N(N_CAND), .M(N_OUT)) u_select (
        .clk    (clk),
        .rst    (rst),
        .cand_i (cand_s1),
        .keep_i (keep_s1),
        .trk_q  (trk_s2)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_pack
        assign out_valid[k]                 = trk_s2[k].valid;
        assign out_rank[k*RANK_W +: RANK_W] = trk_s2[k].rank;
        assign out_id[k*ID_W +: ID_W]       = trk_s2[k].id;
        assign out_idx[k*IDX_W +: IDX_W]    = trk_s2[k].idx;

        // R11: a valid slot names an existing input
        p_idx_in_range_r11: assert property (@(posedge clk) disable iff (rst)
            out_valid[k] |-> (int'(out_idx[k*IDX_W +: IDX_W]) < N_CAND));

        for (genvar m = k + 1; m < N_OUT; m++) begin : g_distinct
            // R11: two valid slots never come from the same input
            p_idx_distinct_r11: assert property (@(posedge clk) disable iff (rst)
                (out_valid[k] && out_valid[m]) |->
                (out_idx[k*IDX_W +: IDX_W] != out_idx[m*IDX_W +: IDX_W]));
        end
    end

    // R1: reset empties the output slots on the following edge
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (out_valid == '0));

    // R12: output slots stay free of shared segments (mode delayed to match)
    p_outputs_disjoint_r12: assert property (@(posedge clk) disable iff (rst)
        (trk_s2[0].valid && trk_s2[1].valid) |->
        !shares_segment(trk_s2[0].id, trk_s2[1].id, $past(geom_s1)));

endmodule

// File: tb/test_trk_best3_sel.sv
module test_trk_best3_sel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        geom_overlap = 1'b0;
    logic [53:0] cand_rank = '0;
    logic [80:0] cand_id = '0;
    logic [2:0]  out_valid;
    logic [17:0] out_rank;
    logic [26:0] out_id;
    logic [11:0] out_idx;

    trk_best3_sel i_trk_best3_sel (
        .clk          (clk),
        .rst          (rst),
        .geom_overlap (geom_overlap),
        .cand_rank    (cand_rank),
        .cand_id      (cand_id),
        .out_valid    (out_valid),
        .out_rank     (out_rank),
        .out_id       (out_id),
        .out_idx      (out_idx)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int r  [9];
    int id [9];
    int ov;

    logic [2:0]  m_v;
    logic [17:0] m_r;
    logic [26:0] m_id;
    logic [11:0] m_x;

    logic [2:0]  pv_q  [2];
    logic [17:0] pr_q  [2];
    logic [26:0] pid_q [2];
    logic [11:0] px_q  [2];
    int          pov_q [2];
    bit          pl_q  [2];
    string       tag_q [2];

    function automatic int fld(int a, int ovm, int f);
        int lo, w;
        if (ovm == 0) begin
            case (f)
                0: begin lo = 6; w = 3; end
                1: begin lo = 4; w = 2; end
                2: begin lo = 2; w = 2; end
                default: begin lo = 0; w = 2; end
            endcase
        end else begin
            case (f)
                0: begin lo = 7; w = 2; end
                1: begin lo = 5; w = 2; end
                2: begin lo = 2; w = 3; end
                default: begin lo = 0; w = 2; end
            endcase
        end
        return (a >> lo) & ((1 << w) - 1);
    endfunction

    function automatic bit clash(int a, int b, int ovm);
        for (int f = 0; f < 4; f++) begin
            if (fld(a, ovm, f) != 0 && fld(a, ovm, f) == fld(b, ovm, f)) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Reference: pairwise removal, then repeated pick of the best remaining.
    task automatic model();
        bit alive [9];
        bit used  [9];
        int best;
        for (int i = 0; i < 9; i++) begin
            alive[i] = (r[i] != 0);
            used[i]  = 1'b0;
            for (int j = 0; j < 9; j++) begin
                if (j != i && r[j] != 0 && clash(id[i], id[j], ov) &&
                    (r[j] > r[i] || (r[j] == r[i] && j < i))) alive[i] = 1'b0;
            end
        end
        m_v = '0; m_r = '0; m_id = '0; m_x = '0;
        for (int k = 0; k < 3; k++) begin
            best = -1;
            for (int i = 0; i < 9; i++) begin
                if (alive[i] && !used[i] && (best < 0 || r[i] > r[best])) best = i;
            end
            if (best >= 0) begin
                used[best]      = 1'b1;
                m_v[k]          = 1'b1;
                m_r[k*6 +: 6]   = 6'(r[best]);
                m_id[k*9 +: 9]  = 9'(id[best]);
                m_x[k*4 +: 4]   = 4'(best);
            end
        end
    endtask

    task automatic apply();
        geom_overlap = ov[0];
        for (int i = 0; i < 9; i++) begin
            cand_rank[i*6 +: 6] = 6'(r[i]);
            cand_id[i*9 +: 9]   = 9'(id[i]);
        end
    endtask

    task automatic clr();
        for (int i = 0; i < 9; i++) begin r[i] = 0; id[i] = 0; end
    endtask

    task automatic compare(string tag, logic [2:0] ev, logic [17:0] er,
                           logic [26:0] ei, logic [11:0] ex, int eov);
        for (int k = 0; k < 3; k++) begin
            checks++;
            if (out_valid[k] !== ev[k] || out_rank[k*6 +: 6] !== er[k*6 +: 6] ||
                out_id[k*9 +: 9] !== ei[k*9 +: 9] || out_idx[k*4 +: 4] !== ex[k*4 +: 4]) begin
                errors++;
                $display("FAIL %s slot %0d: got v=%0b r=%0d id=%03h ix=%0d, exp v=%0b r=%0d id=%03h ix=%0d",
                         tag, k, out_valid[k], out_rank[k*6 +: 6], out_id[k*9 +: 9], out_idx[k*4 +: 4],
                         ev[k], er[k*6 +: 6], ei[k*9 +: 9], ex[k*4 +: 4]);
            end
        end
        // R12 checked directly on the outputs
        checks++;
        for (int a = 0; a < 3; a++) begin
            for (int b = a + 1; b < 3; b++) begin
                if (out_valid[a] && out_valid[b] &&
                    clash(int'(out_id[a*9 +: 9]), int'(out_id[b*9 +: 9]), eov)) begin
                    errors++;
                    $display("FAIL R12 %s: slots %0d,%0d share a segment, got ids %03h %03h, exp disjoint",
                             tag, a, b, out_id[a*9 +: 9], out_id[b*9 +: 9]);
                end
            end
        end
    endtask

    task automatic step(string tag);
        @(negedge clk);
        if (pl_q[1]) compare(tag_q[1], pv_q[1], pr_q[1], pid_q[1], px_q[1], pov_q[1]);
        pv_q[1] = pv_q[0]; pr_q[1] = pr_q[0]; pid_q[1] = pid_q[0];
        px_q[1] = px_q[0]; pov_q[1] = pov_q[0]; pl_q[1] = pl_q[0]; tag_q[1] = tag_q[0];
        apply();
        model();
        pv_q[0] = m_v; pr_q[0] = m_r; pid_q[0] = m_id; px_q[0] = m_x;
        pov_q[0] = ov; pl_q[0] = 1'b1; tag_q[0] = tag;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no end of run, exp finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        pl_q[0] = 1'b0; pl_q[1] = 1'b0;
        // R1: reset holds outputs empty despite live inputs
        clr(); ov = 0;
        r[0] = 40; id[0] = 9'h041; r[3] = 12; id[3] = 9'h100;
        apply();
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 3'b000) begin
            errors++;
            $display("FAIL R1 reset: got valid=%03b, exp 000", out_valid);
        end
        clr(); apply();
        @(negedge clk);
        rst = 1'b0;

        // R4: endcap station 2 match, lower rank removed
        clr(); ov = 0;
        r[0] = 10; id[0] = 9'b000_01_00_00;
        r[1] = 20; id[1] = 9'b000_01_00_10;
        r[2] = 5;  id[2] = 9'b101_00_00_00;
        step("R4 R7 endcap station2");

        // R4 vs R5: same ids, conflict only in overlap layout
        clr(); ov = 0;
        r[4] = 30; id[4] = 9'b001_00_00_00;
        r[6] = 25; id[6] = 9'b011_00_00_00;
        step("R4 endcap no conflict");
        ov = 1;
        step("R5 overlap barrel2 conflict");
        clr(); ov = 1;
        r[1] = 7; id[1] = 9'b00_00_101_00;
        r[2] = 9; id[2] = 9'b11_00_101_00;
        r[8] = 8; id[8] = 9'b00_10_000_00;
        step("R5 overlap endcap1 conflict");

        // R6: all fields zero never conflict; R9 ordering and ties
        clr(); ov = 0;
        for (int i = 0; i < 9; i++) r[i] = (i % 3) + 1;
        step("R6 R9 zero fields ties");

        // R7: equal rank conflict, higher index removed
        clr(); ov = 0;
        r[2] = 15; id[2] = 9'b000_00_11_00;
        r[5] = 15; id[5] = 9'b010_00_11_00;
        r[7] = 3;  id[7] = 9'b000_00_00_01;
        step("R7 tie cancel");

        // R8: chain A>B>C, A-B and B-C share, C still removed by B
        clr(); ov = 0;
        r[0] = 10; id[0] = 9'b000_00_00_11;
        r[1] = 20; id[1] = 9'b000_10_00_11;
        r[2] = 30; id[2] = 9'b000_10_00_00;
        step("R8 chained removal");

        // R3 and R10: empty and sparse sets
        clr(); ov = 0;
        for (int i = 0; i < 9; i++) id[i] = i * 37;
        step("R3 R10 all rank zero");
        r[8] = 1;
        step("R10 R11 single survivor");

        // R2: back-to-back sweep with frequent ties and collisions
        for (int n = 0; n < 4000; n++) begin
            ov = int'($urandom % 2);
            for (int i = 0; i < 9; i++) begin
                r[i]  = (n % 2 == 0) ? int'($urandom % 8) : int'($urandom % 64);
                id[i] = ($urandom % 5 == 0) ? 0 : int'($urandom % 512);
            end
            step("R2 R7 R8 R9 R11 sweep");
        end
        clr();
        step("flush");
        step("flush");

        // R1: reset in the middle of traffic
        @(negedge clk);
        ov = 0; r[0] = 50; id[0] = 9'h1C0; r[1] = 49; id[1] = 9'h003;
        apply();
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 3'b000) begin
            errors++;
            $display("FAIL R1 reset mid traffic: got valid=%03b, exp 000", out_valid);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule